// File: doc/BRIEF.md
# Variable-Split Page Translation Stage

This block performs one stage of two-level address translation. An incoming virtual address is cut into three fields: a top-table index, a second-level index and a page displacement. The top-table index selects an entry in a small internal top table. That entry supplies two things: how many of the following address bits index the second-level table, and a base index into that table. The second-level entry then supplies a page start address. The translated address is that page start plus the displacement. Because every top-level entry chooses its own second-level index width, the position of the displacement boundary differs from one region of the address space to the next.

A configuration port sets the active virtual address length (16 to 64 bits) and the width of the top-table index. A table write port loads either table. One request is handled at a time: the response arrives two cycles after acceptance and carries either the translated address or a fault code. A write access that hits a present page marks that page as modified.

Top module: `pgx_stage`

## Requirements
- R1: A configuration write is taken only when the length is 16 to 64 and the top index width is 1 to TOP_AW. Otherwise the whole write is ignored and the previous settings stay in force.
- R2: A request with any address bit set at or above the active length faults with code 3 (range). This check takes priority over every other check.
- R3: The top-table index is the top T bits of the active address, where T is the configured top index width. The index therefore starts at bit length-1.
- R4: A top entry holds the second-level index width C in bits [5:0] and the base index in bits [6 +: L2_AW]. The second-level slot is base plus the C address bits just below the top index, taken modulo the table depth.
- R5: On a hit, rsp_addr equals the page start plus the low (length - T - C) address bits.
- R6: If C + T exceeds the active length, or C exceeds L2_AW, the request faults with code 2 (split). This check takes priority over the present check.
- R7: A second-level entry holds the page start in bits [OUT_W-1:0], the present flag in bit OUT_W and the modified flag in bit OUT_W+1. A hit on a non-present entry faults with code 1.
- R8: rsp_dirty reports the entry's modified flag as it was before the access. A write hit on a present entry sets that flag. A read leaves it unchanged.
- R9: A request is accepted when req_valid is high and busy is low. busy is high for exactly the one cycle after acceptance. rsp_valid is high for one cycle, two cycles after acceptance. A request held high while busy is not accepted until busy falls.
- R10: A faulted response drives rsp_addr and rsp_dirty to zero. Code 0 means success.
- R11: After reset, busy and rsp_valid are low, the active length is VA_W and the top index width is TOP_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Active virtual address length in bits |
| cfg_top | input | TB_W | Top-table index width |
| tw_en | input | 1 | Table write strobe |
| tw_l2 | input | 1 | Table select: 1 for the second-level table, 0 for the top table |
| tw_addr | input | IDX_W | Table entry index |
| tw_data | input | OUT_W+2 | Entry contents |
| req_valid | input | 1 | Translation request |
| req_wr | input | 1 | Request is a write access |
| req_addr | input | VA_W | Virtual address |
| busy | output | 1 | A request is in flight; new requests wait |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 0 ok, 1 absent, 2 bad split, 3 range |
| rsp_addr | output | OUT_W | Translated address |
| rsp_dirty | output | 1 | Modified flag before this access |

## Verification
A corrupted top entry or a wrong field boundary appears at the ports in the very response that uses it. It shows as a wrong translated address, or as a split fault where a hit was expected. A lost modified-flag update stays hidden until the next access to the same page, which then reports rsp_dirty low. The sweeps therefore touch each page twice. A pipeline timing error shifts rsp_valid away from the two-cycle slot and is caught on the first request.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int CNT_W = 6;
  localparam int MIN_LEN = 16;
  typedef enum logic [1:0] {
    XF_OK     = 2'd0,
    XF_ABSENT = 2'd1,
    XF_SPLIT  = 2'd2,
    XF_RANGE  = 2'd3
  } xfault_e;
endpackage

// File: rtl/pgx_ram.sv
module pgx_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgx_cfg.sv
module pgx_cfg #(
  parameter int VA_W = 64,
  parameter int TOP_AW = 4,
  localparam int LEN_W = $clog2(VA_W + 1),
  localparam int TB_W = $clog2(TOP_AW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TB_W-1:0]  cfg_top,
  output logic [LEN_W-1:0] len_q,
  output logic [TB_W-1:0]  tb_q
);
  import pgx_pkg::*;
  logic legal;
  assign legal = (cfg_len >= LEN_W'(MIN_LEN)) && (cfg_len <= LEN_W'(VA_W)) &&
                 (cfg_top != '0) && (cfg_top <= TB_W'(TOP_AW));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(VA_W);
      tb_q  <= TB_W'(TOP_AW);
    end else if (cfg_we && legal) begin
      len_q <= cfg_len;
      tb_q  <= cfg_top;
    end
  end

  // R1
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (len_q >= LEN_W'(MIN_LEN)) && (len_q <= LEN_W'(VA_W)) && (tb_q != '0));
endmodule

// File: rtl/pgx_split.sv
module pgx_split #(
  parameter int VA_W = 64,
  parameter int TOP_AW = 4,
  parameter int L2_AW = 6,
  localparam int LEN_W = $clog2(VA_W + 1),
  localparam int TB_W = $clog2(TOP_AW + 1),
  localparam int CNT_W = pgx_pkg::CNT_W
) (
  input  logic [VA_W-1:0]  addr,
  input  logic [LEN_W-1:0] len,
  input  logic [TB_W-1:0]  tb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [L2_AW-1:0] base,
  output logic             bad,
  output logic [L2_AW-1:0] l2_idx,
  output logic [VA_W-1:0]  disp
);
  localparam int UW = LEN_W + 1;
  logic [UW-1:0]    used;
  logic [LEN_W-1:0] rem;
  logic [VA_W-1:0]  ones, idx_full;

  always_comb begin
    ones     = '1;
    used     = UW'(tb) + UW'(cnt);
    bad      = (used > UW'(len)) || (cnt > CNT_W'(L2_AW));
    rem      = len - LEN_W'(tb) - LEN_W'(cnt);
    idx_full = (addr >> rem) & ~(ones << cnt);
    l2_idx   = base + idx_full[L2_AW-1:0];
    disp     = addr & ~(ones << rem);
  end
endmodule

// File: rtl/pgx_stage.sv
module pgx_stage #(
  parameter int VA_W = 64,
  parameter int OUT_W = 64,
  parameter int TOP_AW = 4,
  parameter int L2_AW = 6,
  localparam int LEN_W = $clog2(VA_W + 1),
  localparam int TB_W = $clog2(TOP_AW + 1),
  localparam int IDX_W = (TOP_AW > L2_AW) ? TOP_AW : L2_AW,
  localparam int TW_W = OUT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TB_W-1:0]  cfg_top,
  input  logic             tw_en,
  input  logic             tw_l2,
  input  logic [IDX_W-1:0] tw_addr,
  input  logic [TW_W-1:0]  tw_data,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic [VA_W-1:0]  req_addr,
  output logic             busy,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [OUT_W-1:0] rsp_addr,
  output logic             rsp_dirty
);
  import pgx_pkg::*;
  localparam int TOP_DW = CNT_W + L2_AW;
  localparam int L2_DW = OUT_W + 2;

  logic [LEN_W-1:0] len_q;
  logic [TB_W-1:0]  tb_q;

  pgx_cfg #(.VA_W(VA_W), .TOP_AW(TOP_AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_top(cfg_top), .len_q(len_q), .tb_q(tb_q)
  );

  // ---- stage 0: accept, range check, top index ----
  logic             acc, rng0;
  logic [LEN_W-1:0] sh0;
  logic [VA_W-1:0]  ones0, tsel0;
  logic [TOP_AW-1:0] tidx0;

  always_comb begin
    acc   = req_valid && !busy;
    rng0  = (req_addr >> len_q) != '0;
    sh0   = len_q - LEN_W'(tb_q);
    ones0 = '1;
    tsel0 = (req_addr >> sh0) & ~(ones0 << tb_q);
    tidx0 = tsel0[TOP_AW-1:0];
  end

  logic [TOP_DW-1:0] top_rd;
  pgx_ram #(.AW(TOP_AW), .DW(TOP_DW)) u_top (
    .clk(clk), .we(tw_en && !tw_l2), .waddr(tw_addr[TOP_AW-1:0]),
    .wdata(tw_data[TOP_DW-1:0]), .re(acc), .raddr(tidx0), .rdata(top_rd)
  );

  logic             s1_v, w1, rng1;
  logic [VA_W-1:0]  a1;
  logic [LEN_W-1:0] len1;
  logic [TB_W-1:0]  tb1;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= acc;
    if (acc) begin
      a1   <= req_addr;
      w1   <= req_wr;
      rng1 <= rng0;
      len1 <= len_q;
      tb1  <= tb_q;
    end
  end
  assign busy = s1_v;

  // ---- stage 1: field split, second-level read ----
  logic             bad1;
  logic [L2_AW-1:0] l2i1;
  logic [VA_W-1:0]  disp1;

  pgx_split #(.VA_W(VA_W), .TOP_AW(TOP_AW), .L2_AW(L2_AW)) u_split (
    .addr(a1), .len(len1), .tb(tb1), .cnt(top_rd[CNT_W-1:0]),
    .base(top_rd[CNT_W +: L2_AW]), .bad(bad1), .l2_idx(l2i1), .disp(disp1)
  );

  logic             s2_v, w2;
  logic [1:0]       flt2;
  logic [VA_W-1:0]  disp2;
  logic [L2_AW-1:0] l2a2;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    if (s1_v) begin
      w2    <= w1;
      disp2 <= disp1;
      l2a2  <= l2i1;
      flt2  <= rng1 ? XF_RANGE : (bad1 ? XF_SPLIT : XF_OK);
    end
  end

  // ---- stage 2: entry check, modified update, response ----
  logic [L2_DW-1:0] l2_rd, l2_wd;
  logic             present, hit, upd, l2_we;
  logic [L2_AW-1:0] l2_wa;
  logic [1:0]       flt;

  always_comb begin
    present = l2_rd[OUT_W];
    flt     = (flt2 != XF_OK) ? flt2 : (present ? XF_OK : XF_ABSENT);
    hit     = s2_v && (flt == XF_OK);
    upd     = hit && w2;
    l2_we   = (tw_en && tw_l2) || upd;
    if (tw_en && tw_l2) begin
      l2_wa = tw_addr[L2_AW-1:0];
      l2_wd = tw_data;
    end else begin
      l2_wa = l2a2;
      l2_wd = {1'b1, l2_rd[OUT_W:0]};
    end
  end

  pgx_ram #(.AW(L2_AW), .DW(L2_DW)) u_l2 (
    .clk(clk), .we(l2_we), .waddr(l2_wa), .wdata(l2_wd),
    .re(s1_v), .raddr(l2i1), .rdata(l2_rd)
  );

  assign rsp_valid = s2_v;
  assign rsp_fault = s2_v ? flt : 2'd0;
  assign rsp_addr  = hit ? (l2_rd[OUT_W-1:0] + OUT_W'(disp2)) : '0;
  assign rsp_dirty = hit ? l2_rd[OUT_W+1] : 1'b0;

  // R9
  rsp_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |-> ##2 rsp_valid);
  // R9
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(busy));
  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0 && !rsp_dirty));
  // R2
  range_first_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_v && rng1) |=> (rsp_valid && rsp_fault == 2'd3));
endmodule

// File: tb/test_pgx_stage.sv
module test_pgx_stage;
  localparam int VA_W = 64, OUT_W = 64, TOP_AW = 4, L2_AW = 6;
  localparam int LEN_W = $clog2(VA_W + 1), TB_W = $clog2(TOP_AW + 1);
  localparam int IDX_W = 6, TW_W = OUT_W + 2;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, tw_en = 0, tw_l2 = 0, req_valid = 0, req_wr = 0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [TB_W-1:0]  cfg_top = '0;
  logic [IDX_W-1:0] tw_addr = '0;
  logic [TW_W-1:0]  tw_data = '0;
  logic [VA_W-1:0]  req_addr = '0;
  logic busy, rsp_valid, rsp_dirty;
  logic [1:0] rsp_fault;
  logic [OUT_W-1:0] rsp_addr;

  pgx_stage #(.VA_W(VA_W), .OUT_W(OUT_W), .TOP_AW(TOP_AW), .L2_AW(L2_AW)) i_pgx_stage (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_top(cfg_top),
    .tw_en(tw_en), .tw_l2(tw_l2), .tw_addr(tw_addr), .tw_data(tw_data),
    .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_dirty(rsp_dirty)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int m_len = 64, m_tb = 4;
  int top_c [16];
  int top_b [16];
  logic [63:0] l2_pg [64];
  bit l2_p [64];
  bit l2_m [64];

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, got, exp);
    end
  endtask

  task automatic wr_cfg(input int len, input int tb);
    @(negedge clk);
    cfg_we = 1; cfg_len = LEN_W'(len); cfg_top = TB_W'(tb);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_top(input int i, input int c, input int b);
    @(negedge clk);
    tw_en = 1; tw_l2 = 0; tw_addr = IDX_W'(i);
    tw_data = (TW_W'(b) << 6) | TW_W'(c);
    top_c[i] = c; top_b[i] = b;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic wr_l2(input int j, input logic [63:0] pg, input bit p, input bit m);
    @(negedge clk);
    tw_en = 1; tw_l2 = 1; tw_addr = IDX_W'(j);
    tw_data = {m, p, pg};
    l2_pg[j] = pg; l2_p[j] = p; l2_m[j] = m;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic model(input logic [63:0] a, input bit wr,
                       output int f, output logic [63:0] ea, output bit ed);
    logic [63:0] ones, i2;
    int ti, c, rem, j;
    ones = '1; f = 0; ea = '0; ed = 0;
    if (m_len < 64 && (a >> m_len) != 0) f = 3;
    else begin
      ti = int'((a >> (m_len - m_tb)) & ~(ones << m_tb));
      c = top_c[ti];
      if (c + m_tb > m_len || c > L2_AW) f = 2;
      else begin
        rem = m_len - m_tb - c;
        i2 = (a >> rem) & ~(ones << c);
        j = (top_b[ti] + int'(i2 % 64)) % 64;
        if (!l2_p[j]) f = 1;
        else begin
          ea = l2_pg[j] + (a & ~(ones << rem));
          ed = l2_m[j];
          if (wr) l2_m[j] = 1;
        end
      end
    end
  endtask

  // Issue one request, check busy (R9) and the response fields.
  task automatic xlate(input logic [63:0] a, input bit wr, input string rq);
    int f; logic [63:0] ea; bit ed;
    model(a, wr, f, ea, ed);
    @(negedge clk);
    req_valid = 1; req_wr = wr; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R9 busy after accept", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk("R9 rsp_valid two cycles after accept", {63'd0, rsp_valid}, 64'd1);
    chk({rq, " fault code"}, {62'd0, rsp_fault}, 64'(f));
    chk({rq, " address"}, rsp_addr, ea);
    chk({rq, " R8 dirty"}, {63'd0, rsp_dirty}, {63'd0, ed});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", {63'd0, busy}, 64'd0);
    chk("R11 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);

    for (int i = 0; i < 14; i++) wr_top(i, i % 7, (i * 5) % 64);
    wr_top(14, 7, 9);
    wr_top(15, 13, 20);
    for (int j = 0; j < 64; j++)
      wr_l2(j, 64'h0000_1234_0000_0000 + 64'(j) * 64'h1_0000, (j % 7) != 3, (j % 11) == 5);

    // R11 default configuration: full 64-bit length, 4 index bits
    for (int i = 0; i < 14; i++)
      xlate((64'(i) << 60) | 64'h0123_4567_89AB_CDEF, 0, "R11 R3 default cfg");

    // R1 legal configuration, then sweep reads: R3 R4 R5 R6 R7
    wr_cfg(16, 4); m_len = 16; m_tb = 4;
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 8; k++)
        xlate((64'(i) << 12) | 64'((k * 'h2A7 + i * 'h51) & 'hFFF), 0, "R4 R5 R6 R7 sweep len16");

    // R8 write sweep touching each page twice
    for (int i = 0; i < 14; i++)
      for (int k = 0; k < 3; k++) begin
        xlate((64'(i) << 12) | 64'(k * 'h155), 1, "R8 write hit");
        xlate((64'(i) << 12) | 64'(k * 'h155), 0, "R8 reread");
      end

    // R2 range faults
    xlate(64'h1_0000, 0, "R2 bit at length");
    xlate(64'h8000_0000_0000_0005, 1, "R2 top bit");

    // R1 illegal writes ignored: length 15, width 5, width 0
    wr_cfg(15, 2);
    xlate(64'h0000_A5C3, 0, "R1 ignored length 15");
    wr_cfg(20, 5);
    xlate(64'h0000_3C5A, 0, "R1 ignored width 5");
    wr_cfg(20, 0);
    xlate(64'h0000_7E11, 0, "R1 ignored width 0");
    xlate(64'h0001_0000, 0, "R1 R2 length still 16");

    // R1 R3 another legal split: 20 bits, 2 index bits
    wr_cfg(20, 2); m_len = 20; m_tb = 2;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 10; k++)
        xlate((64'(i) << 18) | 64'((k * 'h9B35 + i * 'h777) & 'h3FFFF), k % 2, "R3 R5 sweep len20");
    xlate(64'h10_0000, 0, "R2 bit 20 at len20");

    // R9 request held through busy is accepted only once busy drops
    @(negedge clk);
    req_valid = 1; req_wr = 0; req_addr = 64'h4_1234;
    @(negedge clk);
    chk("R9 busy while held", {63'd0, busy}, 64'd1);
    @(negedge clk);
    req_valid = 0;
    chk("R9 single response", {63'd0, rsp_valid}, 64'd1);
    chk("R9 not re-accepted while busy", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk("R9 no second response", {63'd0, rsp_valid}, 64'd0);
    // R10 faulted response carries zero address
    xlate(64'hFF_0000, 1, "R10 range fault zero fields");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule